// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a 6-bit RF step attenuator that is programmed through a three-wire serial port: a data line, a serial clock and a latch strobe. A new attenuation code arrives on a valid/ready handshake. The block keeps the latch strobe low and shifts the code out most significant bit first, one bit for each rising edge of a serial clock it generates itself. After the final falling clock edge it raises the strobe and lowers it again, so the attenuator takes the whole new code in a single step.

All serial timing comes from the system clock. Each minimum interval (clock high, clock low, clock period, data setup, data hold, strobe setup after the last falling edge, strobe pulse width, spacing between updates) is a parameter in nanoseconds. It is turned into a cycle count, rounded up, from the system clock frequency in MHz. Because of the update spacing, the attenuator is never reprogrammed faster than 25 kHz (at least 40 us between latch events). The handshake stays closed until that spacing has run out.

Top module: `atten_serial_master`

## Requirements
- R1: While reset is asserted and right after it, `ser_clk`, `ser_le` and `ser_data` are low and `req_ready` is high.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the update spacing has elapsed after the strobe falls.
- R3: The accepted code is sent with bit 5 (16 dB weight) first and bit 0 (0.5 dB weight) last, one bit for each of exactly six rising edges of `ser_clk`. A receiver that shifts `ser_data` in at each rising edge holds the requested code when the strobe falls.
- R4: `ser_le` stays low for the whole shift and is never high at the same time as `ser_clk`. It rises only after the sixth falling clock edge, and no sooner than the strobe setup time after that edge.
- R5: `ser_le` is high for at least the strobe pulse width (3 cycles at 100 MHz), then returns low. Exactly one strobe pulse is produced for each accepted request.
- R6: `ser_clk` idles low. Each high phase lasts at least max(high time, half period) rounded up: 5 cycles at 100 MHz. The time from one rising edge to the next is at least the clock period: 10 cycles.
- R7: `ser_data` changes only while `ser_clk` is low and was low in the previous cycle. It is stable for at least the setup time before each rising edge, and it is held for at least the hold time after each falling edge.
- R8: The time from one strobe fall to the next strobe rise is at least the update spacing: 4000 cycles at 100 MHz for 40 us.
- R9: A `req_valid` or `req_word` change while `req_ready` is low has no effect. The code already in flight is the one latched, and no extra transfer follows once `req_valid` has dropped.
- R10: Every phase lasts exactly its derived cycle count, and that count is never below one cycle. At 100 MHz: setup phase 4, high 5, hold 1, strobe setup 1, strobe pulse 3, spacing 4000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A new attenuation code is offered |
| req_word | input | 6 | Attenuation code, bit 5 = 16 dB, bit 0 = 0.5 dB |
| req_ready | output | 1 | Block can accept a code this cycle |
| ser_clk | output | 1 | Generated serial clock, idles low |
| ser_data | output | 1 | Serial data, most significant bit first |
| ser_le | output | 1 | Latch strobe to the attenuator |

## Verification
The assertions assume that the system clock runs at the frequency given by `SYS_MHZ`. They also assume that `req_word` is meaningful only in the cycle a request is taken, so they put no constraint on `req_valid` or `req_word` while the block is busy. The stimulus drives inputs only between clock edges, from a single process. It deliberately toggles `req_valid` and changes `req_word` during busy periods, and it keeps `req_valid` high across the end of the spacing window to produce back-to-back updates. Every other input pattern stays within the handshake rules.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_HIGH   = 3'd2,
      ST_HOLD   = 3'd3,
      ST_LEWAIT = 3'd4,
      ST_LATCH  = 3'd5,
      ST_GAP    = 3'd6
   } seq_state_e;

   // Nanoseconds to system cycles, rounded up.
   function automatic int ns_to_cycles(input int ns, input int mhz);
      return (ns * mhz + 999) / 1000;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   // R10: an expired timer stays expired until reloaded (no wrap)
   a_r10_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !load) |=> done);

endmodule

// File: rtl/atten_shift_word.sv
module atten_shift_word #(
   parameter int WORD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic              shift,
   output logic              msb_out
);

   logic [WORD_W-1:0] sreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sreg <= '0;
      else if (load)
         sreg <= load_word;
      else if (shift)
         sreg <= {sreg[WORD_W-2:0], 1'b0};
   end

   assign msb_out = sreg[WORD_W-1];

   // R3: the sequencer never loads and shifts in the same cycle
   a_r3_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/atten_seq_ctrl.sv
module atten_seq_ctrl
   import atten_ser_pkg::*;
#(
   parameter int WORD_W = 6,
   parameter int CNT_W  = 12,
   parameter int SU_C   = 4,
   parameter int HI_C   = 5,
   parameter int HD_C   = 1,
   parameter int LEW_C  = 1,
   parameter int PW_C   = 3,
   parameter int GAP_C  = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sh_load,
   output logic             sh_shift,
   output logic             req_ready,
   output logic             ser_clk,
   output logic             ser_le
);

   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

   seq_state_e       st, nxt;
   logic [BIT_W-1:0] bit_cnt;
   logic             bit_clr, bit_inc;

   always_comb begin
      nxt      = st;
      tmr_load = 1'b0;
      tmr_val  = '0;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      bit_clr  = 1'b0;
      bit_inc  = 1'b0;
      case (st)
         ST_IDLE: if (req_valid) begin
            nxt      = ST_SETUP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(SU_C - 1);
            sh_load  = 1'b1;
            bit_clr  = 1'b1;
         end
         ST_SETUP: if (tmr_done) begin
            nxt      = ST_HIGH;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HI_C - 1);
         end
         ST_HIGH: if (tmr_done) begin
            nxt      = ST_HOLD;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(HD_C - 1);
         end
         ST_HOLD: if (tmr_done) begin
            tmr_load = 1'b1;
            if (bit_cnt == LAST_BIT) begin
               nxt     = ST_LEWAIT;
               tmr_val = CNT_W'(LEW_C - 1);
            end else begin
               nxt      = ST_SETUP;
               tmr_val  = CNT_W'(SU_C - 1);
               sh_shift = 1'b1;
               bit_inc  = 1'b1;
            end
         end
         ST_LEWAIT: if (tmr_done) begin
            nxt      = ST_LATCH;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(PW_C - 1);
         end
         ST_LATCH: if (tmr_done) begin
            nxt      = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(GAP_C - 1);
         end
         ST_GAP: if (tmr_done) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bit_cnt <= '0;
      end else begin
         st <= nxt;
         if (bit_clr)
            bit_cnt <= '0;
         else if (bit_inc)
            bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign ser_clk   = (st == ST_HIGH);
   assign ser_le    = (st == ST_LATCH);

   // R2: after the strobe falls the handshake is still closed (spacing runs)
   a_r2_closed_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_le) |-> !req_ready);

   // R5: a strobe pulse always ends in the spacing window, never in a new shift
   a_r5_pulse_then_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_le) |-> (!ser_clk && st == ST_GAP));

endmodule

// File: rtl/atten_serial_master.sv
module atten_serial_master
   import atten_ser_pkg::*;
#(
   parameter int WORD_W      = 6,
   parameter int SYS_MHZ     = 100,
   parameter int T_PERIOD_NS = 100,
   parameter int T_HIGH_NS   = 30,
   parameter int T_LOW_NS    = 30,
   parameter int T_SETUP_NS  = 10,
   parameter int T_HOLD_NS   = 10,
   parameter int T_LESU_NS   = 10,
   parameter int T_LEPW_NS   = 30,
   parameter int T_GAP_NS    = 40000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [WORD_W-1:0] req_word,
   output logic              req_ready,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_le
);

   localparam int PER_C = ns_to_cycles(T_PERIOD_NS, SYS_MHZ);
   localparam int HALF_C = (PER_C + 1) / 2;
   localparam int HI_C  = imax(imax(ns_to_cycles(T_HIGH_NS, SYS_MHZ), HALF_C), 1);
   localparam int LO_C  = imax(imax(ns_to_cycles(T_LOW_NS, SYS_MHZ), HALF_C), 1);
   localparam int HD_C  = imax(ns_to_cycles(T_HOLD_NS, SYS_MHZ), 1);
   localparam int SU_C  = imax(imax(ns_to_cycles(T_SETUP_NS, SYS_MHZ), 1), LO_C - HD_C);
   localparam int LEW_C = imax(ns_to_cycles(T_LESU_NS, SYS_MHZ), 1);
   localparam int PW_C  = imax(ns_to_cycles(T_LEPW_NS, SYS_MHZ), 1);
   localparam int GAP_C = imax(ns_to_cycles(T_GAP_NS, SYS_MHZ), 1);
   localparam int MAX_C = imax(imax(imax(SU_C, HI_C), imax(HD_C, LEW_C)), imax(PW_C, GAP_C));
   localparam int CNT_W = $clog2(MAX_C + 1);
   localparam int FC_W  = $clog2(WORD_W + 1);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be at least 2");
      end
      if (SYS_MHZ < 1) begin : g_bad_freq
         $error("SYS_MHZ must be at least 1");
      end
      if (T_PERIOD_NS < 1) begin : g_bad_period
         $error("T_PERIOD_NS must be positive");
      end
   endgenerate

   logic             tmr_load, tmr_done, sh_load, sh_shift;
   logic [CNT_W-1:0] tmr_val;

   atten_seq_ctrl #(
      .WORD_W (WORD_W), .CNT_W (CNT_W), .SU_C (SU_C), .HI_C (HI_C),
      .HD_C (HD_C), .LEW_C (LEW_C), .PW_C (PW_C), .GAP_C (GAP_C)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .sh_load   (sh_load),
      .sh_shift  (sh_shift),
      .req_ready (req_ready),
      .ser_clk   (ser_clk),
      .ser_le    (ser_le)
   );

   atten_phase_timer #(.CNT_W (CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   atten_shift_word #(.WORD_W (WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_word (req_word),
      .shift     (sh_shift),
      .msb_out   (ser_data)
   );

   // Checker state: run lengths observed at the serial pins.
   logic [CNT_W:0] hi_run, le_low_run;
   logic [FC_W-1:0] fall_cnt;
   logic            clk_q, le_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run     <= '0;
         le_low_run <= '0;
         fall_cnt   <= '0;
         clk_q      <= 1'b0;
         le_seen    <= 1'b0;
      end else begin
         clk_q <= ser_clk;
         if (!ser_clk)
            hi_run <= '0;
         else if (hi_run != '1)
            hi_run <= hi_run + 1'b1;
         if (ser_le) begin
            le_low_run <= '0;
            le_seen    <= 1'b1;
         end else if (le_low_run != '1)
            le_low_run <= le_low_run + 1'b1;
         if (ser_le)
            fall_cnt <= '0;
         else if (clk_q && !ser_clk)
            fall_cnt <= fall_cnt + 1'b1;
      end
   end

   // R4: strobe and serial clock never high together
   a_r4_le_clk_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(ser_le && ser_clk));

   // R4: the strobe rises only after all falling edges of the word
   a_r4_le_after_word: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_le) |-> (fall_cnt == FC_W'(WORD_W)));

   // R6: every high phase of the serial clock is long enough
   a_r6_high_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> (hi_run >= (CNT_W + 1)'(HI_C)));

   // R7: data holds across the falling edge
   a_r7_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_clk) |-> $stable(ser_data));

   // R7: data moves only inside a low phase
   a_r7_change_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> (!ser_clk && !$past(ser_clk)));

   // R2: busy on the serial pins means the handshake is closed
   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk || ser_le) |-> !req_ready);

   // R8: spacing between a strobe fall and the next strobe rise
   a_r8_update_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (le_seen && $rose(ser_le)) |-> (le_low_run >= (CNT_W + 1)'(GAP_C)));

endmodule

// File: tb/atten_serial_master_test.sv
module atten_serial_master_test;

   // Cycle counts at 100 MHz, from the requirements (R6, R7, R4, R5, R8, R10).
   localparam int SU  = 4;
   localparam int HI  = 5;
   localparam int HD  = 1;
   localparam int LEW = 1;
   localparam int PW  = 3;
   localparam int GAP = 4000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [5:0] req_word = '0;
   logic       req_ready, ser_clk, ser_data, ser_le;

   int n_checks = 0;
   int n_fail   = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   atten_serial_master uut (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_word (req_word),
      .req_ready (req_ready), .ser_clk (ser_clk), .ser_data (ser_data), .ser_le (ser_le)
   );

   // Expected {clk, data, le} per busy cycle; empty queue means idle.
   logic [2:0] exp_q[$];
   logic [5:0] pend_words[$];

   // Receiver model and timestamps
   logic [5:0] rx_sreg = '0;
   int   rx_rises = 0;
   logic prev_clk = 0, prev_le = 0, prev_data = 0;
   int   cyc = 0, hi_start = 0, last_fall = -1, last_le_fall = -1;
   bit   accepted;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic push_word(input logic [5:0] w);
      for (int i = 5; i >= 0; i--) begin
         for (int k = 0; k < SU; k++) exp_q.push_back({1'b0, w[i], 1'b0});
         for (int k = 0; k < HI; k++) exp_q.push_back({1'b1, w[i], 1'b0});
         for (int k = 0; k < HD; k++) exp_q.push_back({1'b0, w[i], 1'b0});
      end
      for (int k = 0; k < LEW; k++) exp_q.push_back({1'b0, w[0], 1'b0});
      for (int k = 0; k < PW; k++)  exp_q.push_back({1'b0, w[0], 1'b1});
      for (int k = 0; k < GAP; k++) exp_q.push_back({1'b0, w[0], 1'b0});
      pend_words.push_back(w);
   endtask

   task automatic cycle(input logic v, input logic [5:0] w);
      logic [2:0] e;
      @(negedge clk);
      cyc++;
      if (exp_q.size() != 0) begin
         e = exp_q.pop_front();
         chk(ser_clk == e[2], "R6 clock", ser_clk, e[2]);
         chk(ser_data == e[1], "R3 data", ser_data, e[1]);
         chk(ser_le == e[0], "R4 strobe", ser_le, e[0]);
         chk(req_ready == 1'b0, "R2 ready busy", req_ready, 0);
      end else begin
         chk(ser_clk == 1'b0, "R1 idle clock", ser_clk, 0);
         chk(ser_le == 1'b0, "R9 idle strobe", ser_le, 0);
         chk(req_ready == 1'b1, "R2 ready idle", req_ready, 1);
      end
      // R7: data never changes during or at the end of a high phase
      if (ser_data != prev_data)
         chk(!ser_clk && !prev_clk, "R7 data moved near high", ser_clk, 0);
      if (ser_clk && !prev_clk) begin
         rx_sreg = {rx_sreg[4:0], ser_data};
         rx_rises++;
         hi_start = cyc;
      end
      if (!ser_clk && prev_clk) begin
         chk(cyc - hi_start >= HI, "R6 high width", cyc - hi_start, HI);
         last_fall = cyc;
      end
      if (ser_le && !prev_le) begin
         chk(cyc - last_fall >= 1, "R4 strobe setup", cyc - last_fall, 1);
         if (last_le_fall >= 0)
            chk(cyc - last_le_fall >= GAP, "R8 spacing", cyc - last_le_fall, GAP);
         hi_start = cyc;
      end
      if (!ser_le && prev_le) begin
         chk(cyc - hi_start >= PW, "R5 strobe width", cyc - hi_start, PW);
         chk(rx_rises == 6, "R3 edge count", rx_rises, 6);
         if (pend_words.size() != 0)
            chk(rx_sreg == pend_words.pop_front(), "R5 latched word", rx_sreg, 0);
         else
            chk(0, "R5 unexpected latch", rx_sreg, 0);
         rx_rises = 0;
         last_le_fall = cyc;
      end
      prev_clk = ser_clk; prev_le = ser_le; prev_data = ser_data;
      req_valid = v;
      req_word  = w;
      accepted  = v && req_ready && rst_n;
      if (accepted) push_word(w);
   endtask

   task automatic send(input logic [5:0] w);
      accepted = 0;
      while (!accepted) cycle(1'b1, w);
      while (exp_q.size() != 0) cycle(1'b0, 6'h00);
      cycle(1'b0, 6'h00);
   endtask

   initial begin
      // R1: reset state
      for (int i = 0; i < 4; i++) cycle(1'b0, 6'h00);
      chk(ser_data == 1'b0, "R1 reset data", ser_data, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) cycle(1'b0, 6'h00);

      // R3/R5/R10: several patterns
      send(6'h2A);
      send(6'h15);
      send(6'h00);
      send(6'h3F);
      send(6'h20);
      send(6'h01);

      // R9: activity on the request side while busy is ignored
      accepted = 0;
      while (!accepted) cycle(1'b1, 6'h0C);
      for (int i = 0; i < 200; i++) cycle(i[0], 6'h31);
      while (exp_q.size() != 0) cycle(1'b0, 6'h31);
      for (int i = 0; i < 20; i++) cycle(1'b0, 6'h00);
      chk(pend_words.size() == 0, "R9 no extra transfer", pend_words.size(), 0);

      // R8/R2: valid held high gives back-to-back updates at the spacing limit
      accepted = 0;
      while (!accepted) cycle(1'b1, 6'h33);
      accepted = 0;
      while (!accepted) cycle(1'b1, 6'h0E);
      while (exp_q.size() != 0) cycle(1'b0, 6'h00);
      for (int i = 0; i < 10; i++) cycle(1'b0, 6'h00);
      chk(pend_words.size() == 0, "R5 all words latched", pend_words.size(), 0);

      if (!done_flag) begin
         done_flag = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done_flag) begin
         done_flag = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule